// File: doc/BRIEF.md
# Wide-Word Bundle Execution Unit

This unit carries out one wide instruction word at a time. The word holds five slots that all start together: two memory-load slots, an integer slot, an adder slot and a counted-loop slot. The adder slot uses an integer add in place of a floating-point add. Each load slot reads its address from a register and then advances that register. The integer slot can add, subtract or negate. The adder slot sums two registers. The loop slot steps a hidden iteration counter and picks the next program counter.

Every slot reads its sources as they stood when the word was taken in. Results land in the eight-entry register file only when the word retires. Because of this, one register can be a source in one slot and a destination in another slot with no hazard. The word retires when its slowest slot finishes. A slot that finishes early waits for the others. Each load slot talks to memory through its own request/ready handshake, and the memory can take any number of cycles to return data.

Top module: `vliw_bundle_exec`

## Requirements
- R1: After reset, `busy`, `done`, `br_taken`, `wr_conflict`, both `ld_req` bits and all registers are zero. The loop counter is also zero.
- R2: A word is taken in on a rising edge where `start` is high and `busy` is low. A `start` seen while `busy` is high has no effect.
- R3: Every source in a word reads the register value from before that word. A write made by one slot can only be seen by words taken in later.
- R4: If edge E0 takes in the word, `busy` is high after E0 and through to the retire edge R. R is E1 when no load slot is enabled. Otherwise R is one edge after the last enabled load captures its data. `done` is high for exactly the one cycle after R.
- R5: An enabled load slot raises `ld_req` after E0 and holds it, with a steady `ld_addr`, until an edge where `ld_ready` is high. It then captures `ld_rdata` on the first later edge where `ld_valid` is high.
- R6: A load slot uses its address register as the address. At retirement it writes the loaded word to its destination and writes the address plus one back to the address register.
- R7: The integer slot opcode at bits [25:24] works as follows. 0 does nothing, 1 computes a+b, 2 computes a-b and 3 computes 0-a, all modulo 2^16. The destination is at [28:26], a is at [31:29] and b is at [34:32].
- R8: The adder slot is enabled by bit 35. Its destination is at [38:36], and it writes the sum of the registers at [41:39] and [44:42].
- R9: The loop opcode is at bits [1:0] and the target is at [9:2]. Opcode 1 decrements the counter and sets `br_taken` when the new value is nonzero. Opcode 2 loads the counter from the target field and clears `br_taken`. Opcodes 0 and 3 leave the counter unchanged and clear `br_taken`. `br_target` takes the target field at each retirement.
- R10: When several writes in one word name the same register, the later write in this order wins: load0 increment, load0 data, load1 increment, load1 data, integer slot, adder slot. Any such clash sets `wr_conflict`, and it stays set until reset.
- R11: A slot with a no-operation encoding changes no register. The load slots are enabled by bits 10 and 17. Each load field lists the destination first and then the address register, in 3-bit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Take in the word on `bundle` |
| bundle | input | 45 | Wide instruction word |
| busy | output | 1 | A word is in flight |
| done | output | 1 | One-cycle retirement pulse |
| br_taken | output | 1 | Next PC is the loop target (else fall through) |
| br_target | output | 8 | Loop target from the retired word |
| wr_conflict | output | 1 | Sticky same-destination flag |
| ld_req | output | 2 | Per load slot memory request |
| ld_addr | output | 32 | Per load slot address, 16 bits each |
| ld_ready | input | 2 | Per load slot request accepted |
| ld_valid | input | 2 | Per load slot read data valid |
| ld_rdata | input | 32 | Per load slot read data, 16 bits each |

## Verification
For each word, the bench works out the edge at which each load is accepted and the edge at which its data is captured. From those it derives the retire edge: the capture edge of the slowest load plus one, or E1 when there are no loads. The bench samples on the falling edge and compares `busy`, `done`, `ld_req` and `ld_addr` against that timeline on every cycle. It compares the loop outputs and the conflict flag in the one cycle after retirement. Register contents are checked through the address a later load presents. Every such address must match the register values that the reference model committed at the earlier retirement.

// File: rtl/vliw_bundle_exec.sv
module vliw_bundle_exec #(
  parameter int DW  = 16,
  parameter int RIW = 3,
  parameter int PCW = 8,
  localparam int LSW = 1 + 2*RIW,
  localparam int L0  = 2 + PCW,
  localparam int AL  = L0 + 2*LSW,
  localparam int AR  = AL + 2 + 3*RIW,
  localparam int BW  = AR + 1 + 3*RIW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BW-1:0]   bundle,
  output logic            busy,
  output logic            done,
  output logic            br_taken,
  output logic [PCW-1:0]  br_target,
  output logic            wr_conflict,
  output logic [1:0]      ld_req,
  output logic [2*DW-1:0] ld_addr,
  input  logic [1:0]      ld_ready,
  input  logic [1:0]      ld_valid,
  input  logic [2*DW-1:0] ld_rdata
);
  localparam int NREG = 1 << RIW;
  localparam int NW = 6;
  localparam logic [1:0] S_FIN = 2'd0, S_REQ = 2'd1, S_WAIT = 2'd2;

  logic [DW-1:0]  rf [NREG];
  logic [BW-1:0]  bw_q;
  logic           busy_q, done_q, taken_q, conf_q;
  logic [PCW-1:0] tgt_q, cnt_q;
  logic [DW-1:0]  ala_q, alb_q, ara_q, arb_q;
  logic [1:0]     ld_fin;
  logic           wen  [NW];
  logic [RIW-1:0] widx [NW];
  logic [DW-1:0]  wdat [NW];
  logic           clash;
  logic [DW-1:0]  al_res;

  wire start_ok = start && !busy_q;
  wire all_done = busy_q && (&ld_fin);
  wire [1:0] lp_op = bw_q[1:0];
  wire [1:0] al_op = bw_q[AL +: 2];
  wire [PCW-1:0] cnt_dec = cnt_q - 1'b1;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_ld
      localparam int B = L0 + i*LSW;
      logic [1:0]    st;
      logic [DW-1:0] base, dat;

      always_ff @(posedge clk) begin
        if (rst) begin
          st <= S_FIN; base <= '0; dat <= '0;
        end else if (start_ok) begin
          st   <= bundle[B] ? S_REQ : S_FIN;
          base <= rf[bundle[B+1+RIW +: RIW]];
        end else if (st == S_REQ && ld_ready[i]) begin
          st <= S_WAIT;
        end else if (st == S_WAIT && ld_valid[i]) begin
          st  <= S_FIN;
          dat <= ld_rdata[i*DW +: DW];
        end
      end

      assign ld_req[i]          = (st == S_REQ);
      assign ld_addr[i*DW +: DW] = base;
      assign ld_fin[i]          = (st == S_FIN);
      assign wen[2*i]    = bw_q[B];
      assign widx[2*i]   = bw_q[B+1+RIW +: RIW];
      assign wdat[2*i]   = base + 1'b1;
      assign wen[2*i+1]  = bw_q[B];
      assign widx[2*i+1] = bw_q[B+1 +: RIW];
      assign wdat[2*i+1] = dat;

      p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ld_req[i] && !ld_ready[i] |=> ld_req[i] && $stable(ld_addr[i*DW +: DW]));
      p_req_in_flight_r5: assert property (@(posedge clk) disable iff (rst)
        ld_req[i] |-> busy_q);
    end
  endgenerate

  always_comb begin
    case (al_op)
      2'd1:    al_res = ala_q + alb_q;
      2'd2:    al_res = ala_q - alb_q;
      2'd3:    al_res = '0 - ala_q;
      default: al_res = '0;
    endcase
  end

  assign wen[4]  = (al_op != 2'd0);
  assign widx[4] = bw_q[AL+2 +: RIW];
  assign wdat[4] = al_res;
  assign wen[5]  = bw_q[AR];
  assign widx[5] = bw_q[AR+1 +: RIW];
  assign wdat[5] = ara_q + arb_q;

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if (wen[i] && wen[j] && widx[i] == widx[j]) clash = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; taken_q <= 1'b0; conf_q <= 1'b0;
      tgt_q <= '0; cnt_q <= '0; bw_q <= '0;
      ala_q <= '0; alb_q <= '0; ara_q <= '0; arb_q <= '0;
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        bw_q   <= bundle;
        ala_q  <= rf[bundle[AL+2+RIW +: RIW]];
        alb_q  <= rf[bundle[AL+2+2*RIW +: RIW]];
        ara_q  <= rf[bundle[AR+1+RIW +: RIW]];
        arb_q  <= rf[bundle[AR+1+2*RIW +: RIW]];
      end else if (all_done) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        conf_q <= conf_q | clash;
        tgt_q  <= bw_q[2 +: PCW];
        case (lp_op)
          2'd1: begin cnt_q <= cnt_dec; taken_q <= (cnt_dec != '0); end
          2'd2: begin cnt_q <= bw_q[2 +: PCW]; taken_q <= 1'b0; end
          default: taken_q <= 1'b0;
        endcase
        for (int k = 0; k < NW; k++)
          if (wen[k]) rf[widx[k]] <= wdat[k];
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign br_taken    = taken_q;
  assign br_target   = tgt_q;
  assign wr_conflict = conf_q;

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q && !all_done |=> busy_q);
  p_conflict_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    conf_q |=> conf_q);
  p_taken_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    taken_q |-> cnt_q != '0);
endmodule

// File: tb/vliw_bundle_exec_tb.sv
`timescale 1ns/1ps
module vliw_bundle_exec_tb_top;
  localparam int BW = 45, L0 = 10, LSW = 7, AL = 24, AR = 35;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [BW-1:0] bundle = '0;
  logic busy, done, br_taken, wr_conflict;
  logic [7:0] br_target;
  logic [1:0] ld_req, ld_ready = '0, ld_valid = '0;
  logic [31:0] ld_addr, ld_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] m_rf [8];
  logic [7:0] m_cnt = '0;
  bit m_conf = 0;

  always #2 clk = ~clk;

  vliw_bundle_exec dut_i (.clk, .rst, .start, .bundle, .busy, .done, .br_taken,
    .br_target, .wr_conflict, .ld_req, .ld_addr, .ld_ready, .ld_valid, .ld_rdata);

  function automatic logic [15:0] memfn(input logic [15:0] a);
    return (a * 16'd3) ^ 16'h5a3c;
  endfunction

  function automatic logic [BW-1:0] mk(input int lp, imm, e0, d0, a0, e1, d1, a1,
      alop, ald, ala, alb, are, ard, ara, arb);
    logic [BW-1:0] w = '0;
    w[1:0] = 2'(lp); w[9:2] = 8'(imm);
    w[L0] = 1'(e0); w[L0+1 +: 3] = 3'(d0); w[L0+4 +: 3] = 3'(a0);
    w[L0+LSW] = 1'(e1); w[L0+LSW+1 +: 3] = 3'(d1); w[L0+LSW+4 +: 3] = 3'(a1);
    w[AL +: 2] = 2'(alop); w[AL+2 +: 3] = 3'(ald); w[AL+5 +: 3] = 3'(ala); w[AL+8 +: 3] = 3'(alb);
    w[AR] = 1'(are); w[AR+1 +: 3] = 3'(ard); w[AR+4 +: 3] = 3'(ara); w[AR+7 +: 3] = 3'(arb);
    return w;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [BW-1:0] w, input int acc0, lat0, acc1, lat1,
                     input bit stray, input string tg);
    bit e[2]; logic [2:0] d[2], a[2]; logic [15:0] ea[2];
    int ac[2], lt[2];
    int rr;
    bit we[6]; logic [2:0] wi[6]; logic [15:0] wd[6];
    logic [15:0] va, vb;
    bit cf, x_tk; logic [7:0] x_tg;
    ac[0] = acc0; ac[1] = acc1; lt[0] = lat0; lt[1] = lat1;
    rr = 1;
    for (int i = 0; i < 2; i++) begin
      e[i] = w[L0+i*LSW]; d[i] = w[L0+i*LSW+1 +: 3]; a[i] = w[L0+i*LSW+4 +: 3];
      ea[i] = m_rf[a[i]];
      if (e[i] && 3 + ac[i] + lt[i] > rr) rr = 3 + ac[i] + lt[i];
      we[2*i] = e[i]; wi[2*i] = a[i]; wd[2*i] = ea[i] + 16'd1;
      we[2*i+1] = e[i]; wi[2*i+1] = d[i]; wd[2*i+1] = memfn(ea[i]);
    end
    va = m_rf[w[AL+5 +: 3]]; vb = m_rf[w[AL+8 +: 3]];
    we[4] = w[AL +: 2] != 2'd0; wi[4] = w[AL+2 +: 3];
    case (w[AL +: 2])
      2'd1: wd[4] = va + vb;
      2'd2: wd[4] = va - vb;
      default: wd[4] = 16'd0 - va;
    endcase
    we[5] = w[AR]; wi[5] = w[AR+1 +: 3]; wd[5] = m_rf[w[AR+4 +: 3]] + m_rf[w[AR+7 +: 3]];
    cf = 0;
    for (int i = 0; i < 6; i++)
      for (int j = i + 1; j < 6; j++)
        if (we[i] && we[j] && wi[i] == wi[j]) cf = 1;
    m_conf = m_conf | cf;
    x_tg = w[9:2]; x_tk = 0;
    if (w[1:0] == 2'd1) begin m_cnt = m_cnt - 8'd1; x_tk = (m_cnt != 0); end
    else if (w[1:0] == 2'd2) m_cnt = x_tg;
    for (int i = 0; i < 6; i++) if (we[i]) m_rf[wi[i]] = wd[i];

    @(negedge clk); bundle = w; start = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      start = stray && (c == 0);
      chk(busy == (c < rr), "R4 busy", int'(busy), int'(c < rr));
      chk(done == (c == rr), "R4 done", int'(done), int'(c == rr));
      for (int i = 0; i < 2; i++) begin
        chk(ld_req[i] == (e[i] && c <= ac[i]), "R5 ld_req", int'(ld_req[i]), int'(e[i] && c <= ac[i]));
        if (ld_req[i]) chk(ld_addr[i*16 +: 16] == ea[i], {tg, " ld_addr"}, int'(ld_addr[i*16 +: 16]), int'(ea[i]));
        ld_ready[i] = e[i] && (c == ac[i]);
        ld_valid[i] = e[i] && (c == 1 + ac[i] + lt[i]);
        ld_rdata[i*16 +: 16] = ld_valid[i] ? memfn(ea[i]) : 16'hdead;
      end
      if (c == rr) begin
        chk(br_taken == x_tk, "R9 br_taken", int'(br_taken), int'(x_tk));
        chk(br_target == x_tg, "R9 br_target", int'(br_target), int'(x_tg));
        chk(wr_conflict == m_conf, "R10 wr_conflict", int'(wr_conflict), int'(m_conf));
        break;
      end
    end
    start = 1'b0; ld_ready = '0; ld_valid = '0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m_rf[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
    chk(ld_req == 0 && br_taken == 0 && wr_conflict == 0, "R1 outputs", int'({ld_req, br_taken, wr_conflict}), 0);
    // R9 decrement from zero wraps to nonzero: taken
    run(mk(1,8'h40, 0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R9");
    // R6 two loads with different latencies, post-increment of r0 and r3; R1 registers read as zero
    run(mk(0,0, 1,1,0, 1,2,3, 0,0,0,0, 0,0,0,0), 0,0,2,3, 0, "R1");
    // R3 snapshot: r1,r2 read while overwritten in same word
    run(mk(0,0, 1,2,0, 0,0,0, 1,4,1,2, 1,1,2,4), 1,1,0,0, 0, "R6");
    // R7 subtract, R8 add with pre-word r5
    run(mk(0,0, 0,0,0, 0,0,0, 2,5,4,1, 1,6,5,5), 0,0,0,0, 0, "R7");
    run(mk(0,0, 0,0,0, 0,0,0, 3,7,4,0, 0,0,0,0), 0,0,0,0, 0, "R7");
    // observe r5, r7 via load addresses
    run(mk(0,0, 1,0,5, 1,3,7, 0,0,0,0, 0,0,0,0), 3,0,0,4, 0, "R7");
    run(mk(0,0, 1,0,1, 1,3,2, 0,0,0,0, 0,0,0,0), 0,2,1,0, 0, "R8");
    run(mk(0,0, 1,0,6, 1,3,4, 0,0,0,0, 0,0,0,0), 2,2,0,0, 0, "R3");
    // R9 counted loop: set 3, then three decrements with a body add
    run(mk(2,3, 0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R9");
    for (int k = 0; k < 3; k++)
      run(mk(1,8'h21, 0,0,0, 0,0,0, 1,6,6,5, 0,0,0,0), 0,0,0,0, 0, "R9");
    run(mk(0,8'h55, 0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R11");
    run(mk(0,0, 1,2,6, 1,4,0, 0,0,0,0, 0,0,0,0), 1,0,0,1, 0, "R11");
    run(mk(0,0, 1,5,2, 1,7,3, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R11");
    // R10 integer and adder slot both write r3: adder wins, flag sets
    run(mk(0,0, 0,0,0, 0,0,0, 1,3,1,2, 1,3,4,4), 0,0,0,0, 0, "R10");
    run(mk(0,0, 1,1,3, 0,0,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R10");
    // R2 start during busy is ignored
    run(mk(0,0, 1,1,5, 0,0,0, 0,0,0,0, 0,0,0,0), 4,5,0,0, 1, "R2");
    @(negedge clk);
    chk(busy == 0 && ld_req == 0, "R2 stray start", int'({busy, ld_req}), 0);
    // R10 load dst equals address reg: data wins over increment
    run(mk(0,0, 1,0,0, 0,0,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R10");
    run(mk(0,0, 1,1,0, 1,2,7, 1,2,0,7, 0,0,0,0), 2,0,0,3, 0, "R10");
    run(mk(0,0, 1,1,2, 1,3,0, 0,0,0,0, 0,0,0,0), 0,0,0,0, 0, "R10");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule